// File: doc/BRIEF.md
# Analog I/O Board Bus Bridge

This block is the glue logic of a general-purpose analog I/O board that sits on a microcontroller's external 16-bit parallel bus. It decodes byte addresses on word boundaries. Through those addresses it returns results from an analog-to-digital converter, fires that converter's active-low start-of-conversion pulse and holds the 4-bit analog input multiplexer select. It also holds one enable bit that gates all eight DAC outputs, and forwards 14-bit offset-binary words to eight DAC channels.

A bus access is one clock cycle with `bus_rd` or `bus_wr` high. Read data is registered and appears on `bus_rdata` from the next cycle on, which is the single wait state the host inserts. A converter must not see the same channel updated faster than once per hold interval, which is 31 us, or 3875 cycles at 125 MHz. A write that lands inside the interval is therefore parked in a per-channel pending slot and issued when the interval runs out. A per-channel busy flag can be read, so firmware can pace itself. The DAC enable bit resets to zero, so undefined converter contents stay off the outputs after power-up.

Top module: `aio_bridge`

## Requirements
- R1: A read of byte address 0x00 drives `adc_rd_n` low during the access cycle and places `adc_data` unchanged (two's complement) on `bus_rdata` from the following cycle.
- R2: A write to byte address 0x02 drives `adc_conv_n` low for exactly CONV_CYCLES cycles, starting the cycle after the write is sampled. Its data has no effect on any register.
- R3: Byte address 0x04 holds the input select. A write stores data bits 3..0 on `adc_sel`. A read returns them zero-extended. Reset value 0.
- R4: Byte address 0x06 bit 0 is the DAC output enable driving `dac_oe` (1 = outputs on). A read returns it zero-extended. Reset value 0.
- R5: A write to byte address 0x10 + 2k (k = 0..7) to an idle channel produces one cycle of `dac_wr_n` low with `dac_ch` = k and `dac_data` = data bits 13..0, two cycles after the write cycle. Data bits 15..14 are dropped.
- R6: Reads of 0x02, of 0x10..0x1E and of unmapped addresses (e.g. 0x0A) return 0. Writes to unmapped addresses change no register.
- R7: Two DAC strobes for the same channel are at least HOLD_CYCLES cycles apart. A write that arrives sooner is issued exactly HOLD_CYCLES cycles after that channel's previous strobe. A further write before then replaces the pending data, so only the newest value is issued.
- R8: A read of byte address 0x08 returns in bit k a 1 while channel k has a pending write or its hold interval is running, and 0 otherwise. Bits 15..8 read 0.
- R9: After reset `adc_conv_n` and `dac_wr_n` are high and `bus_rdata` is 0. The internal reset is released two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address (bit 0 ignored) |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rdata | output | 16 | Registered read data |
| adc_data | input | 16 | Converter result |
| adc_conv_n | output | 1 | Start-of-conversion, active low |
| adc_rd_n | output | 1 | Converter read enable, active low |
| adc_sel | output | 4 | Analog input select |
| dac_oe | output | 1 | Global DAC output enable |
| dac_wr_n | output | 1 | DAC write strobe, active low |
| dac_ch | output | 3 | DAC channel of the strobe |
| dac_data | output | 14 | DAC data of the strobe |

## Verification
Register writes take effect one cycle after the write cycle, and read data is sampled on the falling edge that follows the read cycle. The convert pulse is counted falling edge by falling edge from that same point. Each DAC write queues an expected strobe stamped with its due cycle. That cycle is two cycles after the write for an idle channel, or the previous strobe of that channel plus HOLD_CYCLES for a held one. A monitor compares channel, data and cycle of every strobe, and at the end the queue must be empty, which also shows that overwritten values were never issued.

// File: rtl/aio_pkg.sv
package aio_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int SEL_W  = 4;
  localparam int DAC_W  = 14;
  localparam int NCH    = 8;
  localparam int CH_W   = $clog2(NCH);
  localparam int WORD_W = ADDR_W - 1;

  // word indices (byte address >> 1)
  localparam logic [WORD_W-1:0] W_ADC  = 4'h0;
  localparam logic [WORD_W-1:0] W_CONV = 4'h1;
  localparam logic [WORD_W-1:0] W_SEL  = 4'h2;
  localparam logic [WORD_W-1:0] W_OE   = 4'h3;
  localparam logic [WORD_W-1:0] W_STAT = 4'h4;
endpackage

// File: rtl/aio_regs.sv
module aio_regs
  import aio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] adc_data,
  input  logic [NCH-1:0]    busy,
  output logic [DATA_W-1:0] rdata,
  output logic              adc_rd_n,
  output logic [SEL_W-1:0]  sel,
  output logic              oe,
  output logic              conv_start,
  output logic              dac_req,
  output logic [CH_W-1:0]   dac_req_ch,
  output logic [DAC_W-1:0]  dac_req_data
);
  logic [WORD_W-1:0] word;
  logic              is_dac;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              oe_q, oe_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              unused_bits;

  assign word        = addr[ADDR_W-1:1];
  assign is_dac      = word[WORD_W-1];
  assign unused_bits = ^{addr[0], wdata[DATA_W-1:DAC_W]};

  always_comb begin
    sel_d   = sel_q;
    oe_d    = oe_q;
    rdata_d = rdata_q;
    if (wr && word == W_SEL) sel_d = wdata[SEL_W-1:0];
    if (wr && word == W_OE)  oe_d  = wdata[0];
    if (rd) begin
      rdata_d = '0;
      if (word == W_ADC)  rdata_d = adc_data;
      if (word == W_SEL)  rdata_d = DATA_W'(sel_q);
      if (word == W_OE)   rdata_d = DATA_W'(oe_q);
      if (word == W_STAT) rdata_d = DATA_W'(busy);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      oe_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      sel_q <= sel_d;
      oe_q  <= oe_d;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign rdata        = rdata_q;
  assign sel          = sel_q;
  assign oe           = oe_q;
  assign adc_rd_n     = ~(rd && word == W_ADC);
  assign conv_start   = wr && word == W_CONV;
  assign dac_req      = wr && is_dac;
  assign dac_req_ch   = word[CH_W-1:0];
  assign dac_req_data = wdata[DAC_W-1:0];

  a_r3_sel_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr[ADDR_W-1:1] == W_SEL) |=> sel == $past(wdata[SEL_W-1:0]));
  a_r4_oe_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr[ADDR_W-1:1] == W_OE) |=> oe == $past(wdata[0]));
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/aio_conv.sv
module aio_conv #(
  parameter int CONV_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic conv_n
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = CNT_W'(CONV_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign conv_n = (cnt_q == '0);

  a_r2_conv_starts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !conv_n);
  generate
    if (CONV_CYCLES >= 2) begin : g_wide
      a_r2_conv_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_n) |=> !conv_n);
    end
  endgenerate
endmodule

// File: rtl/aio_dac_sched.sv
module aio_dac_sched
  import aio_pkg::*;
#(
  parameter int HOLD_CYCLES = 3875
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CH_W-1:0]  req_ch,
  input  logic [DAC_W-1:0] req_data,
  output logic [NCH-1:0]   busy,
  output logic             wr_n,
  output logic [CH_W-1:0]  ch,
  output logic [DAC_W-1:0] data
);
  localparam int TMR_W = $clog2(HOLD_CYCLES + 1);

  logic [NCH-1:0]   pend_q;
  logic [NCH-1:0]   grant;
  logic [TMR_W-1:0] tmr_q  [NCH];
  logic [DAC_W-1:0] slot_q [NCH];
  logic [CH_W-1:0]  gidx;
  logic             gany;
  logic             wr_n_q;
  logic [CH_W-1:0]  ch_q;
  logic [DAC_W-1:0] dat_q;

  // lowest ready channel wins
  always_comb begin
    gidx = '0;
    gany = 1'b0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (pend_q[k] && tmr_q[k] == '0) begin
        gidx = CH_W'(k);
        gany = 1'b1;
      end
    end
    grant = NCH'(gany) << gidx;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic             hit;
    logic             pend_d;
    logic [TMR_W-1:0] tmr_d;

    assign hit = req && req_ch == CH_W'(k);

    always_comb begin
      pend_d = (pend_q[k] && !grant[k]) || hit;
      tmr_d  = tmr_q[k];
      if (grant[k])            tmr_d = TMR_W'(HOLD_CYCLES - 1);
      else if (tmr_q[k] != '0) tmr_d = tmr_q[k] - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[k] <= 1'b0;
        tmr_q[k]  <= '0;
        slot_q[k] <= '0;
      end else begin
        pend_q[k] <= pend_d;
        tmr_q[k]  <= tmr_d;
        if (hit) slot_q[k] <= req_data;
      end
    end

    assign busy[k] = pend_q[k] || tmr_q[k] != '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q <= 1'b1;
      ch_q   <= '0;
      dat_q  <= '0;
    end else begin
      wr_n_q <= ~gany;
      if (gany) begin
        ch_q  <= gidx;
        dat_q <= slot_q[gidx];
      end
    end
  end

  assign wr_n = wr_n_q;
  assign ch   = ch_q;
  assign data = dat_q;

  a_r5_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_q |-> $past(|pend_q));
  a_r7_hold_started: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_q |-> busy[ch_q]);
  a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/aio_bridge.sv
module aio_bridge
  import aio_pkg::*;
#(
  parameter int CONV_CYCLES = 8,
  parameter int HOLD_CYCLES = 3875
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_conv_n,
  output logic              adc_rd_n,
  output logic [SEL_W-1:0]  adc_sel,
  output logic              dac_oe,
  output logic              dac_wr_n,
  output logic [CH_W-1:0]   dac_ch,
  output logic [DAC_W-1:0]  dac_data
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             conv_start;
  logic             dac_req;
  logic [CH_W-1:0]  dac_req_ch;
  logic [DAC_W-1:0] dac_req_data;
  logic [NCH-1:0]   busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  aio_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .addr         (bus_addr),
    .wdata        (bus_wdata),
    .rd           (bus_rd),
    .wr           (bus_wr),
    .adc_data     (adc_data),
    .busy         (busy),
    .rdata        (bus_rdata),
    .adc_rd_n     (adc_rd_n),
    .sel          (adc_sel),
    .oe           (dac_oe),
    .conv_start   (conv_start),
    .dac_req      (dac_req),
    .dac_req_ch   (dac_req_ch),
    .dac_req_data (dac_req_data)
  );

  aio_conv #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (conv_start),
    .conv_n (adc_conv_n)
  );

  aio_dac_sched #(.HOLD_CYCLES(HOLD_CYCLES)) u_sched (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req      (dac_req),
    .req_ch   (dac_req_ch),
    .req_data (dac_req_data),
    .busy     (busy),
    .wr_n     (dac_wr_n),
    .ch       (dac_ch),
    .data     (dac_data)
  );

  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (adc_conv_n && dac_wr_n && !dac_oe));
endmodule

// File: tb/test_aio_bridge.sv
module test_aio_bridge;
  localparam int CONV = 8;
  localparam int HOLD = 3875;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_rdata;
  logic [15:0] adc_data = '0;
  logic        adc_conv_n, adc_rd_n, dac_oe, dac_wr_n;
  logic [3:0]  adc_sel;
  logic [2:0]  dac_ch;
  logic [13:0] dac_data;

  aio_bridge #(.CONV_CYCLES(CONV), .HOLD_CYCLES(HOLD)) i_aio_bridge (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .adc_data(adc_data), .adc_conv_n(adc_conv_n), .adc_rd_n(adc_rd_n),
    .adc_sel(adc_sel), .dac_oe(dac_oe), .dac_wr_n(dac_wr_n),
    .dac_ch(dac_ch), .dac_data(dac_data)
  );

  always #4 clk = ~clk;

  typedef struct { int ch; int data; int due; } exp_t;
  exp_t sbq[$];
  int   last_iss [8];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !dac_wr_n) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R7 unexpected strobe", int'(dac_ch), -1);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(int'(dac_ch) == e.ch, "R5 channel", int'(dac_ch), e.ch);
        chk(int'(dac_data) == e.data, "R5 data", int'(dac_data), e.data);
        chk(cyc == e.due, "R7 strobe cycle", cyc, e.due);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d, output int n);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; n = cyc;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [15:0] d, output logic rdn);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 rdn = adc_rd_n;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic dac_write(input int c, input logic [15:0] d, input bit push);
    int n, due;
    bus_write(5'(8'h10 + 2 * c), d, n);
    due = n + 2;
    if (last_iss[c] + HOLD > due) due = last_iss[c] + HOLD;
    if (push) begin
      sbq.push_back('{c, int'(d[13:0]), due});
      last_iss[c] = due;
    end
  endtask

  initial begin
    logic [15:0] rd;
    logic        rdn;
    int          n;
    for (int i = 0; i < 8; i++) last_iss[i] = -100000;

    repeat (3) @(negedge clk);
    // R9: outputs held during reset
    chk(adc_conv_n && dac_wr_n && bus_rdata == 0, "R9 reset outputs",
        {adc_conv_n, dac_wr_n}, 3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(adc_sel == 0, "R3 reset select", adc_sel, 0);
    chk(dac_oe == 0, "R4 reset enable", dac_oe, 0);

    // R3 input select
    bus_write(5'h04, 16'hFFF5, n);
    chk(adc_sel == 4'h5, "R3 select drive", adc_sel, 5);
    bus_read(5'h04, rd, rdn);
    chk(rd == 16'h0005, "R3 select readback", rd, 5);

    // R4 output enable
    bus_write(5'h06, 16'hFFFF, n);
    chk(dac_oe == 1, "R4 enable set", dac_oe, 1);
    bus_read(5'h06, rd, rdn);
    chk(rd == 16'h0001, "R4 enable readback", rd, 1);
    bus_write(5'h06, 16'h0002, n);
    chk(dac_oe == 0, "R4 enable clear", dac_oe, 0);

    // R1 converter result
    adc_data = 16'h8001;
    bus_read(5'h00, rd, rdn);
    chk(rdn == 1'b0, "R1 rd strobe low", rdn, 0);
    chk(rd == 16'h8001, "R1 result", rd, 16'h8001);
    adc_data = 16'h7FFE;
    bus_read(5'h00, rd, rdn);
    chk(rd == 16'h7FFE, "R1 positive result", rd, 16'h7FFE);
    bus_read(5'h04, rd, rdn);
    chk(rdn == 1'b1, "R1 rd strobe idle", rdn, 1);

    // R2 convert pulse
    chk(adc_conv_n == 1, "R2 idle high", adc_conv_n, 1);
    bus_write(5'h02, 16'hFFFF, n);
    for (int i = 0; i < CONV; i++) begin
      chk(adc_conv_n == 0, "R2 pulse low", adc_conv_n, 0);
      @(negedge clk);
    end
    chk(adc_conv_n == 1, "R2 pulse end", adc_conv_n, 1);
    chk(adc_sel == 4'h5 && dac_oe == 0, "R2 data ignored", {adc_sel, dac_oe}, 8'h0A);

    // R6 write-only and unmapped
    bus_read(5'h02, rd, rdn);
    chk(rd == 0, "R6 convert reads zero", rd, 0);
    bus_read(5'h12, rd, rdn);
    chk(rd == 0, "R6 dac reads zero", rd, 0);
    bus_read(5'h0A, rd, rdn);
    chk(rd == 0, "R6 unmapped reads zero", rd, 0);
    bus_write(5'h0C, 16'hFFFF, n);
    chk(adc_sel == 4'h5 && dac_oe == 0 && dac_wr_n, "R6 unmapped write ignored",
        {adc_sel, dac_oe}, 8'h0A);

    // R5 all channels, top bits dropped
    for (int c = 0; c < 8; c++) dac_write(c, 16'hC000 | 16'(c * 16'h0111 + 3), 1'b1);

    // R7 early rewrite held; R8 busy
    dac_write(3, 16'h2ABC, 1'b1);
    bus_read(5'h08, rd, rdn);
    chk(rd == 16'h00FF, "R8 busy all", rd, 16'h00FF);
    repeat (HOLD + 40) @(negedge clk);
    bus_read(5'h08, rd, rdn);
    chk(rd == 16'h0008, "R8 busy only held channel", rd, 8);
    repeat (HOLD) @(negedge clk);
    bus_read(5'h08, rd, rdn);
    chk(rd == 16'h0000, "R8 busy clear", rd, 0);

    // R7 overwrite of pending data
    dac_write(6, 16'h0111, 1'b1);
    dac_write(6, 16'h0222, 1'b0);
    dac_write(6, 16'h0333, 1'b1);
    repeat (HOLD + 40) @(negedge clk);
    chk(sbq.size() == 0, "R7 all strobes seen", sbq.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule